// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Tracker

This block follows one memory rank of eight banks, cycle by cycle, and says which commands may be issued now. Each cycle it takes at most one command: activate, read, write, precharge or refresh, with a bank number. It keeps, for every bank, whether a row is open and how many cycles remain before each kind of follow-up command becomes legal. From this it drives legality flags for every bank and command kind, plus the open/closed map of the rank. A command scheduler reads the flags before it picks a command. It can also feed its choice back and receive an error pulse when the choice broke the protocol or a spacing rule.

Spacings come from timing fields held quasi-static by the user. They may change only while reset is asserted or the rank is idle. Before use, the block raises these fields to floors. Any field of zero counts as one cycle. Read-to-precharge is never shorter than the four-clock burst. The row-active time is never shorter than CAS plus activate-to-column plus the effective read-to-precharge. A write latency of zero selects CAS minus one.

The command input carries no back-pressure. The block never stalls a command: it accepts a legal one and drops a flagged one, so there is no ready signal. All outputs are plain status pins.

Top module: `dram_bank_tracker`

## Requirements
- R1: While and after reset, every bank reads closed (bank_open = 0), activate and refresh are legal for all banks, reads/writes are not legal, and both error pulses are 0.
- R2: After an accepted activate to bank b at edge k, a read or write to b is legal from edge k+max(t_rcd,1) onward, and not before.
- R3: After an accepted activate, a precharge to that bank waits N cycles, where N = max(t_ras, max(t_cas,1)+max(t_rcd,1)+max(t_rtp,4)).
- R4: After an accepted read, a precharge to that bank waits at least max(t_rtp,4) cycles from the read, combined (by maximum) with any wait still pending.
- R5: After an accepted write, a precharge to that bank waits W+4+max(t_wr,1) cycles, where W = t_cwl if nonzero, else max(max(t_cas,1)-1,1).
- R6: After a precharge accepted on an open bank, an activate to it waits max(t_rp,1) cycles. A precharge to a closed bank is legal (outside refresh) and changes no state.
- R7: A refresh is legal only when all banks are closed and their precharge waits have expired. After an accepted refresh, no command of any kind is legal for max(t_rfc,1) cycles.
- R8: A read/write to a closed bank, an activate to an open bank, or a refresh with any bank open raises proto_err for one cycle, on the cycle after the command. The command is dropped.
- R9: Any other command that is not legal when issued raises timing_err for one cycle, on the cycle after the command, and is dropped. The two error pulses never occur together.
- R10: Opcodes are 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, and 6–7 act as idle. Banks are independent, and bit b of every per-bank vector belongs to bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Command opcode (see R10) |
| cmd_bank | input | BW (3) | Target bank |
| t_cas | input | TW (6) | Read CAS latency, cycles |
| t_rcd | input | TW | Activate to read/write |
| t_rp | input | TW | Precharge to activate |
| t_ras | input | TW | Activate to precharge, before floor |
| t_rtp | input | TW | Read to precharge, before floor |
| t_wr | input | TW | Write recovery |
| t_rfc | input | TW | Refresh cycle time |
| t_cwl | input | TW | Write latency, 0 = automatic |
| ok_act | output | NBANK (8) | Activate legal per bank |
| ok_col | output | NBANK | Read/write legal per bank |
| ok_pre | output | NBANK | Precharge legal per bank |
| ok_ref | output | 1 | Refresh legal |
| bank_open | output | NBANK | Row open per bank |
| proto_err | output | 1 | Protocol violation pulse |
| timing_err | output | 1 | Spacing violation pulse |

## Verification
The bench builds the block with its defaults: eight banks and 6-bit timing fields, which give 8-bit internal counters. It runs three register sets. The first has a small t_ras and t_rtp, so both floors act, and uses automatic write latency. The second has large explicit values that leave the floors idle. The third is all zeros, which drives every field to its one-cycle minimum. With these sets, every floor branch, the reload of a pending precharge wait by a later read or write, and back-to-back one-cycle spacings all occur within a few thousand cycles.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } op_e;

  // data burst occupies this many clocks; floors read-to-precharge
  localparam int BURST_CLK = 4;
endpackage

// File: rtl/tt_clamp.sv
// Raises programmed fields to their floors and returns "cycles minus one"
// reload values for the countdown timers.
module tt_clamp #(
  parameter int TW = 6,
  parameter int CW = TW + 2
) (
  input  logic [TW-1:0] cas,
  input  logic [TW-1:0] rcd,
  input  logic [TW-1:0] rp,
  input  logic [TW-1:0] ras,
  input  logic [TW-1:0] rtp,
  input  logic [TW-1:0] wr,
  input  logic [TW-1:0] rfc,
  input  logic [TW-1:0] cwl,
  output logic [CW-1:0] ld_rcd,
  output logic [CW-1:0] ld_ras,
  output logic [CW-1:0] ld_rtp,
  output logic [CW-1:0] ld_wrp,
  output logic [CW-1:0] ld_rp,
  output logic [CW-1:0] ld_rfc
);
  import tt_pkg::*;

  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] BURST = CW'(BURST_CLK);

  logic [CW-1:0] cas_e, rcd_e, rp_e, rtp_e, wr_e, rfc_e, cwl_e;
  logic [CW-1:0] row_min, ras_e, wrp_e;

  function automatic logic [CW-1:0] floor1(input logic [TW-1:0] v);
    return (v == '0) ? ONE : CW'(v);
  endfunction

  always_comb begin
    cas_e   = floor1(cas);
    rcd_e   = floor1(rcd);
    rp_e    = floor1(rp);
    wr_e    = floor1(wr);
    rfc_e   = floor1(rfc);
    rtp_e   = (CW'(rtp) < BURST) ? BURST : CW'(rtp);
    cwl_e   = (cwl != '0) ? CW'(cwl) : ((cas_e > ONE) ? cas_e - ONE : ONE);
    row_min = cas_e + rcd_e + rtp_e;
    ras_e   = (CW'(ras) < row_min) ? row_min : CW'(ras);
    wrp_e   = cwl_e + BURST + wr_e;
  end

  assign ld_rcd = rcd_e - ONE;
  assign ld_ras = ras_e - ONE;
  assign ld_rtp = rtp_e - ONE;
  assign ld_wrp = wrp_e - ONE;
  assign ld_rp  = rp_e  - ONE;
  assign ld_rfc = rfc_e - ONE;
endmodule

// File: rtl/tt_bank.sv
// State of one bank: open flag and three countdown timers.
module tt_bank #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_act,
  input  logic          hit_rd,
  input  logic          hit_wr,
  input  logic          hit_pre,
  input  logic [CW-1:0] ld_rcd,
  input  logic [CW-1:0] ld_ras,
  input  logic [CW-1:0] ld_rtp,
  input  logic [CW-1:0] ld_wrp,
  input  logic [CW-1:0] ld_rp,
  output logic          is_open,
  output logic          act_rdy,
  output logic          col_rdy,
  output logic          pre_rdy
);
  logic [CW-1:0] c_col, c_pre, c_act;
  logic [CW-1:0] col_dn, pre_dn, act_dn, pre_nx;

  always_comb begin
    col_dn = (c_col == '0) ? '0 : c_col - CW'(1);
    pre_dn = (c_pre == '0) ? '0 : c_pre - CW'(1);
    act_dn = (c_act == '0) ? '0 : c_act - CW'(1);
    pre_nx = pre_dn;
    if (hit_act)                         pre_nx = ld_ras;
    else if (hit_rd && ld_rtp > pre_dn)  pre_nx = ld_rtp;
    else if (hit_wr && ld_wrp > pre_dn)  pre_nx = ld_wrp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      c_col   <= '0;
      c_pre   <= '0;
      c_act   <= '0;
    end else begin
      c_col <= hit_act ? ld_rcd : col_dn;
      c_pre <= pre_nx;
      c_act <= (hit_pre && is_open) ? ld_rp : act_dn;
      if (hit_act)      is_open <= 1'b1;
      else if (hit_pre) is_open <= 1'b0;
    end
  end

  assign act_rdy = !is_open && (c_act == '0);
  assign col_rdy = is_open && (c_col == '0);
  assign pre_rdy = !is_open || (c_pre == '0);

  // R2
  col_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd || hit_wr) |-> (is_open && c_col == '0));

  // R3
  pre_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pre && is_open) |-> (c_pre == '0));

  // R8
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_act |=> is_open);
endmodule

// File: rtl/tt_refresh.sv
// Rank-wide busy window following a refresh.
module tt_refresh #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] ld_rfc,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= ld_rfc;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R7
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NBANK = 8,
  parameter int TW    = 6,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = TW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [TW-1:0]    t_cas,
  input  logic [TW-1:0]    t_rcd,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_ras,
  input  logic [TW-1:0]    t_rtp,
  input  logic [TW-1:0]    t_wr,
  input  logic [TW-1:0]    t_rfc,
  input  logic [TW-1:0]    t_cwl,
  output logic [NBANK-1:0] ok_act,
  output logic [NBANK-1:0] ok_col,
  output logic [NBANK-1:0] ok_pre,
  output logic             ok_ref,
  output logic [NBANK-1:0] bank_open,
  output logic             proto_err,
  output logic             timing_err
);
  import tt_pkg::*;

  logic [CW-1:0] ld_rcd, ld_ras, ld_rtp, ld_wrp, ld_rp, ld_rfc;
  logic [NBANK-1:0] act_rdy, col_rdy, pre_rdy;
  logic rf_busy;
  op_e  op;
  logic is_cmd, legal, bad_proto, acc;

  tt_clamp #(.TW(TW), .CW(CW)) u_clamp (
    .cas(t_cas), .rcd(t_rcd), .rp(t_rp), .ras(t_ras), .rtp(t_rtp),
    .wr(t_wr), .rfc(t_rfc), .cwl(t_cwl),
    .ld_rcd(ld_rcd), .ld_ras(ld_ras), .ld_rtp(ld_rtp),
    .ld_wrp(ld_wrp), .ld_rp(ld_rp), .ld_rfc(ld_rfc)
  );

  assign op = op_e'(cmd_op);
  assign ok_act = act_rdy & {NBANK{!rf_busy}};
  assign ok_col = col_rdy & {NBANK{!rf_busy}};
  assign ok_pre = pre_rdy & {NBANK{!rf_busy}};
  assign ok_ref = (&act_rdy) && !rf_busy;

  always_comb begin
    is_cmd    = 1'b1;
    legal     = 1'b0;
    bad_proto = 1'b0;
    case (op)
      OP_ACT: begin legal = ok_act[cmd_bank]; bad_proto = bank_open[cmd_bank];  end
      OP_RD,
      OP_WR:  begin legal = ok_col[cmd_bank]; bad_proto = !bank_open[cmd_bank]; end
      OP_PRE: legal = ok_pre[cmd_bank];
      OP_REF: begin legal = ok_ref;           bad_proto = |bank_open;           end
      default: is_cmd = 1'b0;
    endcase
  end

  assign acc = cmd_valid && legal;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel;
    assign sel = acc && (cmd_bank == BW'(g));
    tt_bank #(.CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .hit_act(sel && op == OP_ACT), .hit_rd(sel && op == OP_RD),
      .hit_wr(sel && op == OP_WR),   .hit_pre(sel && op == OP_PRE),
      .ld_rcd(ld_rcd), .ld_ras(ld_ras), .ld_rtp(ld_rtp),
      .ld_wrp(ld_wrp), .ld_rp(ld_rp),
      .is_open(bank_open[g]), .act_rdy(act_rdy[g]),
      .col_rdy(col_rdy[g]),   .pre_rdy(pre_rdy[g])
    );
  end

  tt_refresh #(.CW(CW)) u_refresh (
    .clk(clk), .rst_n(rst_n), .start(acc && op == OP_REF),
    .ld_rfc(ld_rfc), .busy(rf_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto_err  <= 1'b0;
      timing_err <= 1'b0;
    end else begin
      proto_err  <= cmd_valid && is_cmd && bad_proto;
      timing_err <= cmd_valid && is_cmd && !bad_proto && !legal;
    end
  end

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(proto_err && timing_err));
endmodule

// File: tb/test_dram_bank_tracker.sv
`timescale 1ns/1ps
module test_dram_bank_tracker;
  localparam int NB = 8;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic [TW-1:0] t_cas, t_rcd, t_rp, t_ras, t_rtp, t_wr, t_rfc, t_cwl;
  logic [NB-1:0] ok_act, ok_col, ok_pre, bank_open;
  logic ok_ref, proto_err, timing_err;

  dram_bank_tracker #(.NBANK(NB), .TW(TW)) i_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .t_cas(t_cas), .t_rcd(t_rcd), .t_rp(t_rp),
    .t_ras(t_ras), .t_rtp(t_rtp), .t_wr(t_wr), .t_rfc(t_rfc), .t_cwl(t_cwl),
    .ok_act(ok_act), .ok_col(ok_col), .ok_pre(ok_pre), .ok_ref(ok_ref),
    .bank_open(bank_open), .proto_err(proto_err), .timing_err(timing_err)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int e_rcd, e_ras, e_rtp, e_wrp, e_rp, e_rfc;
  bit m_open[NB];
  int m_col[NB], m_pre[NB], m_act[NB];
  int m_ref;
  bit exp_p, exp_t;

  function automatic int fl1(int v); return (v < 1) ? 1 : v; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  task automatic set_cfg(int cas, int rcd, int rp, int ras, int rtp, int wr, int rfc, int cwl);
    int c_e, w_e;
    t_cas = TW'(cas); t_rcd = TW'(rcd); t_rp = TW'(rp); t_ras = TW'(ras);
    t_rtp = TW'(rtp); t_wr = TW'(wr); t_rfc = TW'(rfc); t_cwl = TW'(cwl);
    c_e   = fl1(cas);
    e_rcd = fl1(rcd);
    e_rp  = fl1(rp);
    e_rfc = fl1(rfc);
    e_rtp = imax(rtp, 4);
    e_ras = imax(ras, c_e + e_rcd + e_rtp);
    w_e   = (cwl != 0) ? cwl : fl1(c_e - 1);
    e_wrp = w_e + 4 + fl1(wr);
  endtask

  function automatic bit all_idle();
    for (int i = 0; i < NB; i++) if (m_open[i] || m_act[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_legal(int op, int b);
    if (m_ref != 0) return 1'b0;
    case (op)
      1: return !m_open[b] && m_act[b] == 0;
      2, 3: return m_open[b] && m_col[b] == 0;
      4: return !m_open[b] || m_pre[b] == 0;
      5: return all_idle();
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_proto(int op, int b);
    bit any = 1'b0;
    for (int i = 0; i < NB; i++) any |= m_open[i];
    case (op)
      1: return m_open[b];
      2, 3: return !m_open[b];
      5: return any;
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 1'b0; m_col[i] = 0; m_pre[i] = 0; m_act[i] = 0;
    end
    m_ref = 0; exp_p = 1'b0; exp_t = 1'b0;
  endtask

  task automatic m_update(int op, int b);
    bit acc;
    acc = m_legal(op, b);
    for (int i = 0; i < NB; i++) begin
      if (m_col[i] > 0) m_col[i]--;
      if (m_pre[i] > 0) m_pre[i]--;
      if (m_act[i] > 0) m_act[i]--;
    end
    if (m_ref > 0) m_ref--;
    if (acc) begin
      case (op)
        1: begin m_open[b] = 1'b1; m_col[b] = e_rcd - 1; m_pre[b] = e_ras - 1; end
        2: m_pre[b] = imax(m_pre[b], e_rtp - 1);
        3: m_pre[b] = imax(m_pre[b], e_wrp - 1);
        4: if (m_open[b]) begin m_open[b] = 1'b0; m_act[b] = e_rp - 1; end
        5: m_ref = e_rfc - 1;
        default: ;
      endcase
    end
  endtask

  task automatic chk(bit ok, string req, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] xa, xc, xp, xo;
    for (int i = 0; i < NB; i++) begin
      xa[i] = m_legal(1, i);
      xc[i] = m_legal(2, i);
      xp[i] = m_legal(4, i);
      xo[i] = m_open[i];
    end
    chk(ok_act == xa, "R6", "ok_act", int'(ok_act), int'(xa));
    chk(ok_col == xc, "R2", "ok_col", int'(ok_col), int'(xc));
    chk(ok_pre == xp, "R3,R4,R5", "ok_pre", int'(ok_pre), int'(xp));
    chk(ok_ref == m_legal(5, 0), "R7", "ok_ref", int'(ok_ref), int'(m_legal(5, 0)));
    chk(bank_open == xo, "R10", "bank_open", int'(bank_open), int'(xo));
    chk(proto_err == exp_p, "R8", "proto_err", int'(proto_err), int'(exp_p));
    chk(timing_err == exp_t, "R9", "timing_err", int'(timing_err), int'(exp_t));
  endtask

  // one command per cycle; outputs are sampled at the falling edge
  task automatic cyc(int op, int b);
    @(negedge clk);
    compare_all();
    exp_p = m_proto(op, b);
    exp_t = (op >= 1 && op <= 5) && !exp_p && !m_legal(op, b);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_bank  = 3'(b);
    @(posedge clk);
    m_update(op, b);
  endtask

  task automatic wait_legal(int op, int b);
    for (int k = 0; k < 300 && !m_legal(op, b); k++) cyc(0, 0);
    cyc(op, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bank_open == '0, "R1", "bank_open", int'(bank_open), 0);
    chk(ok_act == '1, "R1", "ok_act", int'(ok_act), 'hff);
    chk(ok_col == '0, "R1", "ok_col", int'(ok_col), 0);
    chk(ok_ref == 1'b1, "R1", "ok_ref", int'(ok_ref), 1);
    chk(!proto_err && !timing_err, "R1", "errors", int'({proto_err, timing_err}), 0);
  endtask

  task automatic directed();
    cyc(1, 2);            // activate bank 2
    cyc(2, 2);            // early read: R2 timing error unless spacing is 1
    wait_legal(2, 2);     // R4 read
    cyc(4, 2);            // early precharge
    wait_legal(3, 2);     // R5 write extends precharge wait
    cyc(1, 2);            // R8 activate to open bank
    cyc(2, 5);            // R8 read to closed bank
    cyc(5, 0);            // R8 refresh with bank open
    wait_legal(4, 2);     // R3 precharge
    cyc(4, 6);            // R6 precharge to closed bank: no effect
    cyc(7, 3);            // R10 opcode 7 acts as idle
    cyc(5, 0);            // R7 refresh during precharge wait
    wait_legal(5, 0);     // R7 refresh
    cyc(1, 4);            // R7 activate during refresh window
    for (int k = 0; k < 70; k++) cyc(0, 0);
    cyc(1, 0); cyc(1, 7); // R10 two banks independently
    for (int k = 0; k < 20; k++) cyc(0, 0);
  endtask

  task automatic random_run(int n);
    for (int k = 0; k < n; k++) begin
      int r, op, b;
      r = $urandom_range(0, 99);
      b = $urandom_range(0, NB - 1);
      op = (r < 30) ? 1 : (r < 48) ? 2 : (r < 66) ? 3 : (r < 88) ? 4 : (r < 94) ? 5 : r % 8;
      if (!m_legal(op, b) && $urandom_range(0, 9) < 6) op = 0;
      cyc(op, b);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    // floors active, automatic write latency
    set_cfg(5, 3, 2, 4, 1, 2, 6, 0);
    do_reset(); directed(); random_run(4000);
    // large explicit values
    set_cfg(9, 6, 5, 30, 5, 9, 20, 7);
    do_reset(); directed(); random_run(4000);
    // all zero: one-cycle minimums
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    do_reset(); directed(); random_run(4000);
    @(negedge clk); cmd_valid = 1'b0;
    finish_run();
  end
endmodule